// File: doc/BRIEF.md
# Integer Execution Unit with Operand Steering

This block is the integer arithmetic stage of a small 32-bit pipelined core. In each cycle it picks its two operands, computes one function of them, and stores that value in an output register. Operand A is either a register value or the program counter. Operand B is either a second register value or a decoded immediate. Because operand A can be the program counter, the same adder produces PC-relative addresses. A pass-through function forwards operand B unchanged, which is how upper-immediate loads are handled.

The function is chosen by a 4-bit code and one shared modifier bit. With the add code, the modifier turns addition into subtraction. With the right-shift code, it turns a zero-filling shift into a sign-filling shift. The signed and unsigned less-than functions give a 0/1 result, and the branch logic downstream uses it for less-than and greater-or-equal conditions. Branches that test for equality use a zero test on the subtract result. That test, the instruction decoder and the register file all sit outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_q` is loaded with zero at that edge.
- R2: With `rst` low, `result_q` after each rising edge holds the function of the inputs sampled at that edge, so the latency is one cycle.
- R3: Operand A is `reg_a` when `a_use_pc` is 0 and `pc_in` when it is 1.
- R4: Operand B is `reg_b` when `b_use_imm` is 0 and `imm_in` when it is 1.
- R5: Code 4'b0000 gives A+B when `func_alt` is 0 and A−B when it is 1, both modulo 2^32.
- R6: Code 4'b0001 gives A XOR B, code 4'b0010 gives A OR B, and code 4'b0011 gives A AND B.
- R7: Code 4'b0100 shifts A left, filling with zeros, by the amount in B[4:0]. The higher bits of B are not used.
- R8: Code 4'b0101 shifts A right by B[4:0]. The fill is zeros when `func_alt` is 0 and copies of A[31] when it is 1.
- R9: Code 4'b0110 gives 32'd1 if A is less than B as signed numbers and 32'd0 otherwise. Code 4'b0111 does the same comparison as unsigned numbers.
- R10: Code 4'b1000 gives operand B unchanged.
- R11: Codes 4'b1001 to 4'b1111 give zero.
- R12: `func_alt` has no effect on any code other than 4'b0000 and 4'b0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_use_pc | input | 1 | Operand A steering: 0 selects register, 1 selects program counter |
| b_use_imm | input | 1 | Operand B steering: 0 selects register, 1 selects immediate |
| func_code | input | 4 | Function select |
| func_alt | input | 1 | Modifier: subtract / arithmetic right shift |
| reg_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand |
| pc_in | input | 32 | Program counter value |
| imm_in | input | 32 | Decoded immediate |
| result_q | output | 32 | Registered result |

## Verification
The bound checker tests several properties on every cycle: the clearing done by reset, zero results for unused codes, the 0/1 form of both compare results, the zero bits left behind by left shifts and by logical right shifts, the pass-through of operand B, and PC-relative steering when the immediate is zero. Full values need the bench's reference functions, applied to seeded random operands and to directed cases. Those cases cover subtraction that wraps, sign-filled shifts by 31, shift amounts with bits set above bit 4, signed and unsigned compares that disagree, and the modifier toggled on functions it must not affect.

// File: rtl/exec_unit_pkg.sv
package exec_unit_pkg;

  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD   = 4'd0,
    FN_XOR   = 4'd1,
    FN_OR    = 4'd2,
    FN_AND   = 4'd3,
    FN_SHL   = 4'd4,
    FN_SHR   = 4'd5,
    FN_SLT   = 4'd6,
    FN_SLTU  = 4'd7,
    FN_PASSB = 4'd8
  } fn_code_e;

endpackage

// File: rtl/exec_opsel.sv
module exec_opsel #(
  parameter int WIDTH = 32
) (
  input  logic             a_use_pc,
  input  logic             b_use_imm,
  input  logic [WIDTH-1:0] reg_a,
  input  logic [WIDTH-1:0] reg_b,
  input  logic [WIDTH-1:0] pc_in,
  input  logic [WIDTH-1:0] imm_in,
  output logic [WIDTH-1:0] opnd_a,
  output logic [WIDTH-1:0] opnd_b
);

  function automatic logic [WIDTH-1:0] pick(input logic sel,
                                            input logic [WIDTH-1:0] when0,
                                            input logic [WIDTH-1:0] when1);
    return sel ? when1 : when0;
  endfunction

  assign opnd_a = pick(a_use_pc, reg_a, pc_in);
  assign opnd_b = pick(b_use_imm, reg_b, imm_in);

endmodule

// File: rtl/exec_addcmp.sv
module exec_addcmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             lt_signed,
  output logic             lt_unsigned
);

  // Adds with an optional inverted B plus carry-in; returns carry out on top.
  function automatic logic [WIDTH:0] add_ext(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic inv);
    logic [WIDTH-1:0] yy;
    yy = inv ? ~y : y;
    return {1'b0, x} + {1'b0, yy} + {{WIDTH{1'b0}}, inv};
  endfunction

  logic [WIDTH:0] full;
  logic           carry;
  logic           ovf;

  assign full  = add_ext(opnd_a, opnd_b, do_sub);
  assign sum   = full[WIDTH-1:0];
  assign carry = full[WIDTH];
  // Subtraction overflows when the signs of A and B differ and the sign of the
  // difference does not match the sign of A.
  assign ovf   = (opnd_a[WIDTH-1] != opnd_b[WIDTH-1]) &&
                 (sum[WIDTH-1] != opnd_a[WIDTH-1]);

  // These flags are meaningful only when do_sub is set.
  assign lt_unsigned = ~carry;
  assign lt_signed   = sum[WIDTH-1] ^ ovf;

endmodule

// File: rtl/exec_shift.sv
module exec_shift #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [SHW-1:0]   amount,
  input  logic             to_left,
  input  logic             arith,
  output logic [WIDTH-1:0] data_out
);

  function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] stage [0:SHW];
  logic             fill;

  // A left shift is done as a right shift of the bit-reversed word.
  assign stage[0] = to_left ? flip(data_in) : data_in;
  assign fill     = arith & ~to_left & data_in[WIDTH-1];

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amount[s]
                      ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
                      : stage[s];
  end

  assign data_out = to_left ? flip(stage[SHW]) : stage[SHW];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_unit_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_use_pc,
  input  logic             b_use_imm,
  input  logic [3:0]       func_code,
  input  logic             func_alt,
  input  logic [WIDTH-1:0] reg_a,
  input  logic [WIDTH-1:0] reg_b,
  input  logic [WIDTH-1:0] pc_in,
  input  logic [WIDTH-1:0] imm_in,
  output logic [WIDTH-1:0] result_q
);

  logic [WIDTH-1:0] opnd_a;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] sum_raw;
  logic [WIDTH-1:0] shift_raw;
  logic             lt_s;
  logic             lt_u;
  logic             adder_sub;
  logic             shift_left;
  logic             shift_arith;
  logic [WIDTH-1:0] next_result;

  function automatic logic [WIDTH-1:0] bitwise(input logic [3:0] code,
                                               input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y);
    case (code)
      FN_XOR:  return x ^ y;
      FN_OR:   return x | y;
      default: return x & y;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] as_bool(input logic f);
    return {{(WIDTH-1){1'b0}}, f};
  endfunction

  exec_opsel #(.WIDTH(WIDTH)) u_opsel (
    .a_use_pc (a_use_pc),
    .b_use_imm(b_use_imm),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .pc_in    (pc_in),
    .imm_in   (imm_in),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b)
  );

  // The compare codes always subtract; the modifier only matters for the add code.
  assign adder_sub = ((func_code == FN_ADD) & func_alt) |
                     (func_code == FN_SLT) | (func_code == FN_SLTU);

  exec_addcmp #(.WIDTH(WIDTH)) u_addcmp (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .do_sub     (adder_sub),
    .sum        (sum_raw),
    .lt_signed  (lt_s),
    .lt_unsigned(lt_u)
  );

  assign shift_left  = (func_code == FN_SHL);
  assign shift_arith = func_alt & (func_code == FN_SHR);

  exec_shift #(.WIDTH(WIDTH)) u_shift (
    .data_in (opnd_a),
    .amount  (opnd_b[SHW-1:0]),
    .to_left (shift_left),
    .arith   (shift_arith),
    .data_out(shift_raw)
  );

  always_comb begin
    case (func_code)
      FN_ADD:                 next_result = sum_raw;
      FN_XOR, FN_OR, FN_AND:  next_result = bitwise(func_code, opnd_a, opnd_b);
      FN_SHL, FN_SHR:         next_result = shift_raw;
      FN_SLT:                 next_result = as_bool(lt_s);
      FN_SLTU:                next_result = as_bool(lt_u);
      FN_PASSB:               next_result = opnd_b;
      default:                next_result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result_q <= '0;
    else     result_q <= next_result;
  end

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             a_use_pc,
  input logic             b_use_imm,
  input logic [3:0]       func_code,
  input logic             func_alt,
  input logic [WIDTH-1:0] reg_b,
  input logic [WIDTH-1:0] pc_in,
  input logic [WIDTH-1:0] imm_in,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result_q
);

  function automatic logic [WIDTH-1:0] low_mask(input logic [SHW-1:0] n);
    return (WIDTH'(1) << n) - WIDTH'(1);
  endfunction

  function automatic logic [WIDTH-1:0] high_mask(input logic [SHW-1:0] n);
    return ~({WIDTH{1'b1}} >> n);
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result_q == '0)); // R1

  AST_UNUSED_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (func_code > 4'd8) |=> (result_q == '0)); // R11

  AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (rst)
    (func_code == 4'd6 || func_code == 4'd7) |=> (result_q[WIDTH-1:1] == '0)); // R9

  AST_SHL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (func_code == 4'd4) |=> ((result_q & low_mask($past(opnd_b[SHW-1:0]))) == '0)); // R7

  AST_SHR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (func_code == 4'd5 && !func_alt) |=>
      ((result_q & high_mask($past(opnd_b[SHW-1:0]))) == '0)); // R8

  AST_PASS_B: assert property (@(posedge clk) disable iff (rst)
    (func_code == 4'd8) |=> (result_q == $past(b_use_imm ? imm_in : reg_b))); // R10

  AST_PC_RELATIVE: assert property (@(posedge clk) disable iff (rst)
    (func_code == 4'd0 && !func_alt && a_use_pc && b_use_imm && imm_in == '0)
      |=> (result_q == $past(pc_in))); // R3

endmodule

bind int_exec_unit int_exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_use_pc (a_use_pc),
  .b_use_imm(b_use_imm),
  .func_code(func_code),
  .func_alt (func_alt),
  .reg_b    (reg_b),
  .pc_in    (pc_in),
  .imm_in   (imm_in),
  .opnd_b   (opnd_b),
  .result_q (result_q)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_use_pc = 1'b0;
  logic        b_use_imm = 1'b0;
  logic [3:0]  func_code = 4'd0;
  logic        func_alt = 1'b0;
  logic [31:0] reg_a = 32'h1234_5678;
  logic [31:0] reg_b = 32'h0F0F_0F0F;
  logic [31:0] pc_in = 32'h0000_1000;
  logic [31:0] imm_in = 32'hFFFF_FFF0;
  logic [31:0] result_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .a_use_pc(a_use_pc), .b_use_imm(b_use_imm),
    .func_code(func_code), .func_alt(func_alt), .reg_a(reg_a), .reg_b(reg_b),
    .pc_in(pc_in), .imm_in(imm_in), .result_q(result_q)
  );

  function automatic logic [31:0] model(input logic [3:0] c, input logic alt,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [4:0] sh;
    sh = b[4:0];
    case (c)
      4'd0: return alt ? a - b : a + b;
      4'd1: return a ^ b;
      4'd2: return a | b;
      4'd3: return a & b;
      4'd4: return a << sh;
      4'd5: return alt ? 32'($signed(a) >>> sh) : a >> sh;
      4'd6: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd7: return (a < b) ? 32'd1 : 32'd0;
      4'd8: return b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0: return "R5";
      4'd1, 4'd2, 4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6, 4'd7: return "R9";
      4'd8: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: result_q=%h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic run_op(input string tag, input logic [3:0] c, input logic alt,
                        input logic upc, input logic uimm,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] pc, input logic [31:0] imm);
    logic [31:0] ea, eb;
    func_code = c; func_alt = alt; a_use_pc = upc; b_use_imm = uimm;
    reg_a = a; reg_b = b; pc_in = pc; imm_in = imm;
    ea = upc ? pc : a;
    eb = uimm ? imm : b;
    @(negedge clk);
    check(tag, result_q, model(c, alt, ea, eb));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: result_q=%h expected completion", result_q);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2017));
    func_code = 4'd1;
    repeat (3) @(negedge clk);
    check("R1 reset state", result_q, 32'd0);
    rst = 1'b0;

    // Directed corners
    run_op("R5 add", 4'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd0);
    run_op("R5 sub wrap", 4'd0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 32'd0, 32'd0);
    run_op("R3 pc-relative", 4'd0, 1'b0, 1'b1, 1'b1, 32'hDEAD_0000, 32'h5, 32'h0000_4000, 32'h0000_0010);
    run_op("R4 imm operand", 4'd2, 1'b0, 1'b0, 1'b1, 32'h0000_00F0, 32'hFFFF_FFFF, 32'd7, 32'h0000_000F);
    run_op("R7 shl high amount bits", 4'd4, 1'b0, 1'b0, 1'b0, 32'h0000_0003, 32'hFFFF_FFE5, 32'd0, 32'd0);
    run_op("R8 sra by 31", 4'd5, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'd31, 32'd0, 32'd0);
    run_op("R8 srl by 31", 4'd5, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'd31, 32'd0, 32'd0);
    run_op("R9 signed lt", 4'd6, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'd1, 32'd0, 32'd0);
    run_op("R9 unsigned lt", 4'd7, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'd1, 32'd0, 32'd0);
    run_op("R9 signed equal", 4'd6, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'd0, 32'd0);
    run_op("R10 pass imm", 4'd8, 1'b1, 1'b1, 1'b1, 32'h1, 32'h2, 32'h3, 32'hABCD_E000);
    run_op("R11 unused code", 4'd9, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0);
    run_op("R11 unused code 15", 4'd15, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h1, 32'd0, 32'd0);
    run_op("R12 alt on xor", 4'd1, 1'b1, 1'b0, 1'b0, 32'hA5A5_A5A5, 32'h0F0F_0F0F, 32'd0, 32'd0);
    run_op("R12 alt on shl", 4'd4, 1'b1, 1'b0, 1'b0, 32'h8000_0001, 32'd1, 32'd0, 32'd0);
    run_op("R12 alt on sltu", 4'd7, 1'b1, 1'b0, 1'b0, 32'd5, 32'd3, 32'd0, 32'd0);

    // R2: back-to-back different ops, each visible exactly one cycle later
    run_op("R2 back-to-back a", 4'd3, 1'b0, 1'b0, 1'b0, 32'hF0F0_1234, 32'hFF00_FF00, 32'd0, 32'd0);
    run_op("R2 back-to-back b", 4'd0, 1'b1, 1'b0, 1'b0, 32'd100, 32'd58, 32'd0, 32'd0);

    // Mid-run reset with a nonzero op pending
    func_code = 4'd8; b_use_imm = 1'b1; imm_in = 32'hFFFF_FFFF; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", result_q, 32'd0);
    rst = 1'b0;

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      logic [31:0] a, b;
      c = ($urandom % 8 == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      a = $urandom;
      b = ($urandom % 4 == 0) ? a ^ 32'($urandom % 2) : $urandom;
      run_op({"R2 random ", tag_of(c)}, c, 1'($urandom), 1'($urandom), 1'($urandom),
             a, b, $urandom, $urandom);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule